// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block buffers 32-bit audio words between a register bus and a serial audio engine. Words written by the bus enter a transmit queue that the engine drains one word per pop. Words pushed by the engine enter a receive queue that the bus drains one word per read. Both queues are eight entries deep. Each queue presents its head word combinationally, so a pop or read takes the word on the output in that same cycle.

Each direction has a 4-bit threshold select. The transmit threshold flag asks for more data when the queue is nearly empty. The receive threshold flag asks for service when the queue is filling up. Misuse of either queue is recorded in a sticky flag: a write into a full queue, or a read from an empty one. Each queue has a flush strobe. Six interrupt-enable bits gate the six flags into a single registered interrupt request. The serial shifting, the clock dividers and the bus decode are not part of this block.

Top module: `audio_fifo_pair`

## Requirements
- R1: Words written with `bus_wr` leave on `eng_tx_data` in write order. `eng_tx_data` shows the oldest word and reads 0 while the queue is empty. `tx_count` gives the fill level, from 0 to 8.
- R2: Words pushed with `eng_push` leave on `bus_rdata` in push order. `bus_rdata` shows the oldest word and reads 0 while the queue is empty. `rx_count` gives the fill level.
- R3: A threshold select from 0 to 7 means a level equal to that value. Any select with bit 3 set means level 8, which is the full queue.
- R4: `flags[0]` (transmit threshold) is 1 exactly when `tx_count` is less than or equal to the transmit level.
- R5: `flags[3]` (receive threshold) is 1 exactly when `rx_count` is greater than or equal to the receive level.
- R6: A write into a full queue is dropped and leaves the count at 8 and the stored words unchanged. It sets the sticky overflow flag: `flags[1]` for transmit, `flags[4]` for receive.
- R7: A pop or read on an empty queue returns 0 and changes no count. It sets the sticky underflow flag: `flags[2]` for transmit, `flags[5]` for receive.
- R8: While `flag_clr_we` is high, each `flag_clr_mask` bit that is 1 clears the sticky flag at the same bit position. A flag being set in the same cycle wins over the clear. Mask bits 0 and 3 have no effect.
- R9: A flush strobe (`tx_flush` or `rx_flush`) empties its queue and clears that queue's two sticky flags. The result is visible in the next cycle. Writes, reads, pushes and pops to that queue in the flush cycle are ignored.
- R10: `irq` is registered. In each cycle it equals the OR, over the previous cycle, of every flag ANDed with its enable bit. The enable bits use the same positions as `flags` and are loaded from `irq_en_wdata` when `irq_en_we` is high.
- R11: After reset both queues are empty, all sticky flags and enable bits are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write one word into the transmit queue |
| bus_wdata | input | 32 | Word written into the transmit queue |
| bus_rd | input | 1 | Read one word from the receive queue |
| bus_rdata | output | 32 | Head of the receive queue, 0 when empty |
| eng_pop | input | 1 | Engine takes one word from the transmit queue |
| eng_tx_data | output | 32 | Head of the transmit queue, 0 when empty |
| eng_push | input | 1 | Engine stores one word into the receive queue |
| eng_rx_data | input | 32 | Word pushed into the receive queue |
| tx_flush | input | 1 | Flush strobe for the transmit queue |
| rx_flush | input | 1 | Flush strobe for the receive queue |
| tx_lvl_sel | input | 4 | Transmit threshold select |
| rx_lvl_sel | input | 4 | Receive threshold select |
| flag_clr_we | input | 1 | Sticky flag clear strobe |
| flag_clr_mask | input | 6 | Write-one-to-clear mask, positions as in `flags` |
| irq_en_we | input | 1 | Load the interrupt enables |
| irq_en_wdata | input | 6 | New interrupt enable bits |
| tx_count | output | 4 | Transmit queue fill level |
| rx_count | output | 4 | Receive queue fill level |
| flags | output | 6 | {rx underflow, rx overflow, rx threshold, tx underflow, tx overflow, tx threshold} |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest condition to reach from the ports is a flush that lands while the queue is full, its overflow flag is set, and a write arrives in the same cycle. This condition shows whether the flush wins over both the access and the sticky set. The stimulus first overfills the transmit queue and then issues the flush together with a write. The saturated threshold is also hard to reach, because the receive threshold flag only rises when the queue is completely full. The stimulus pushes nine words, moves the select through values above 7, and then drains one word to watch the flag fall.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int FLAG_N  = 6;
  localparam int TX_TRIG = 0;
  localparam int TX_OVF  = 1;
  localparam int TX_UDF  = 2;
  localparam int RX_TRIG = 3;
  localparam int RX_OVF  = 4;
  localparam int RX_UDF  = 5;
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             ovf,
  output logic             udf,
  input  logic             clr_ovf,
  input  logic             clr_udf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] count_q, count_n;
  logic ovf_q, ovf_n, udf_q, udf_n;
  logic full, empty, do_wr, do_rd;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (count_q == CW'(DEPTH));
    empty    = (count_q == '0);
    do_wr    = wr_en && !full && !flush;
    do_rd    = rd_en && !empty && !flush;
    wr_ptr_n = flush ? '0 : (do_wr ? ptr_inc(wr_ptr_q) : wr_ptr_q);
    rd_ptr_n = flush ? '0 : (do_rd ? ptr_inc(rd_ptr_q) : rd_ptr_q);
    count_n  = flush ? '0 : count_q + CW'(do_wr) - CW'(do_rd);
    if (flush)              ovf_n = 1'b0;
    else if (wr_en && full) ovf_n = 1'b1;
    else if (clr_ovf)       ovf_n = 1'b0;
    else                    ovf_n = ovf_q;
    if (flush)               udf_n = 1'b0;
    else if (rd_en && empty) udf_n = 1'b1;
    else if (clr_udf)        udf_n = 1'b0;
    else                     udf_n = udf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      count_q  <= count_n;
      ovf_q    <= ovf_n;
      udf_q    <= udf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = empty ? '0 : mem[rd_ptr_q];
  assign count   = count_q;
  assign ovf     = ovf_q;
  assign udf     = udf_q;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0) && !ovf_q && !udf_q);
  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> ovf_q);
  assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !flush) |=> (count_q == CW'(DEPTH)));
  assert_udf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !flush) |=> udf_q);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf && !flush) |=> ovf_q);
endmodule

// File: rtl/afp_trig.sv
module afp_trig #(
  parameter int DEPTH = 8,
  parameter int SEL_W = 4,
  parameter bit LE    = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [CW-1:0]    count,
  output logic             hit
);
  logic [CW-1:0] level;

  always_comb begin
    level = sel[SEL_W-1] ? CW'(DEPTH) : CW'(sel[SEL_W-2:0]);
  end

  generate
    if (LE) begin : g_le
      assign hit = (count <= level);
      assert_empty_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> hit);
      assert_sat_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[SEL_W-1] |-> hit);
    end else begin : g_ge
      assign hit = (count >= level);
      assert_full_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> hit);
      assert_sat_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[SEL_W-1] |-> (hit == (count == CW'(DEPTH))));
    end
  endgenerate
endmodule

// File: rtl/afp_irq.sv
module afp_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic         irq
);
  logic [N-1:0] en_q, en_n;
  logic irq_q, irq_n;

  always_comb begin
    en_n  = en_we ? en_wdata : en_q;
    irq_n = |(flags & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      irq_q <= irq_n;
    end
  end

  assign irq = irq_q;

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) == '0) |-> !irq_q);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(flags & en_q)));
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int SEL_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [WIDTH-1:0]           bus_wdata,
  input  logic                       bus_rd,
  output logic [WIDTH-1:0]           bus_rdata,
  input  logic                       eng_pop,
  output logic [WIDTH-1:0]           eng_tx_data,
  input  logic                       eng_push,
  input  logic [WIDTH-1:0]           eng_rx_data,
  input  logic                       tx_flush,
  input  logic                       rx_flush,
  input  logic [SEL_W-1:0]           tx_lvl_sel,
  input  logic [SEL_W-1:0]           rx_lvl_sel,
  input  logic                       flag_clr_we,
  input  logic [5:0]                 flag_clr_mask,
  input  logic                       irq_en_we,
  input  logic [5:0]                 irq_en_wdata,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic [5:0]                 flags,
  output logic                       irq
);
  import afp_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic tx_ovf, tx_udf, rx_ovf, rx_udf, tx_hit, rx_hit;
  logic [CW-1:0] tx_cnt, rx_cnt;

  afp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .wr_en(bus_wr), .wr_data(bus_wdata),
    .rd_en(eng_pop), .rd_data(eng_tx_data),
    .count(tx_cnt), .ovf(tx_ovf), .udf(tx_udf),
    .clr_ovf(flag_clr_we && flag_clr_mask[TX_OVF]),
    .clr_udf(flag_clr_we && flag_clr_mask[TX_UDF])
  );

  afp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .wr_en(eng_push), .wr_data(eng_rx_data),
    .rd_en(bus_rd), .rd_data(bus_rdata),
    .count(rx_cnt), .ovf(rx_ovf), .udf(rx_udf),
    .clr_ovf(flag_clr_we && flag_clr_mask[RX_OVF]),
    .clr_udf(flag_clr_we && flag_clr_mask[RX_UDF])
  );

  afp_trig #(.DEPTH(DEPTH), .SEL_W(SEL_W), .LE(1'b1)) u_tx_trig (
    .clk(clk), .rst_n(rst_n), .sel(tx_lvl_sel), .count(tx_cnt), .hit(tx_hit)
  );

  afp_trig #(.DEPTH(DEPTH), .SEL_W(SEL_W), .LE(1'b0)) u_rx_trig (
    .clk(clk), .rst_n(rst_n), .sel(rx_lvl_sel), .count(rx_cnt), .hit(rx_hit)
  );

  always_comb begin
    flags          = '0;
    flags[TX_TRIG] = tx_hit;
    flags[TX_OVF]  = tx_ovf;
    flags[TX_UDF]  = tx_udf;
    flags[RX_TRIG] = rx_hit;
    flags[RX_OVF]  = rx_ovf;
    flags[RX_UDF]  = rx_udf;
  end

  afp_irq #(.N(FLAG_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags),
    .en_we(irq_en_we), .en_wdata(irq_en_wdata), .irq(irq)
  );

  assign tx_count = tx_cnt;
  assign rx_count = rx_cnt;
endmodule

// File: tb/audio_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module audio_fifo_pair_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd, eng_pop, eng_push, tx_flush, rx_flush;
  logic flag_clr_we, irq_en_we;
  logic [31:0] bus_wdata, bus_rdata, eng_tx_data, eng_rx_data;
  logic [3:0] tx_lvl_sel, rx_lvl_sel, tx_count, rx_count;
  logic [5:0] flag_clr_mask, irq_en_wdata, flags;
  logic irq;

  always #2 clk = ~clk;

  audio_fifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .eng_pop(eng_pop),
    .eng_tx_data(eng_tx_data), .eng_push(eng_push), .eng_rx_data(eng_rx_data),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_lvl_sel(tx_lvl_sel),
    .rx_lvl_sel(rx_lvl_sel), .flag_clr_we(flag_clr_we),
    .flag_clr_mask(flag_clr_mask), .irq_en_we(irq_en_we),
    .irq_en_wdata(irq_en_wdata), .tx_count(tx_count), .rx_count(rx_count),
    .flags(flags), .irq(irq)
  );

  // scoreboard state
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic m_tx_ovf, m_tx_udf, m_rx_ovf, m_rx_udf;
  logic [5:0] en_m;
  logic irq_exp;
  int n_checks = 0;
  int n_err = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lvl(logic [3:0] s);
    return s[3] ? 8 : int'(s[2:0]);
  endfunction

  function automatic logic [5:0] mflags();
    logic [5:0] f;
    f[0] = (txq.size() <= lvl(tx_lvl_sel));
    f[1] = m_tx_ovf;
    f[2] = m_tx_udf;
    f[3] = (rxq.size() >= lvl(rx_lvl_sel));
    f[4] = m_rx_ovf;
    f[5] = m_rx_udf;
    return f;
  endfunction

  task automatic step();
    logic nirq;
    nirq = |(mflags() & en_m);
    @(posedge clk);
    #1;
    irq_exp = nirq;
  endtask

  task automatic check_state(string req);
    check({req, " tx_count"}, 32'(tx_count), 32'(txq.size()));
    check({req, " rx_count"}, 32'(rx_count), 32'(rxq.size()));
    check({req, " flags"}, 32'(flags), 32'(mflags()));
    check({req, " irq"}, 32'(irq), 32'(irq_exp));
  endtask

  // driver: expected words enter the scoreboard queue
  task automatic tx_write(logic [31:0] d);
    bus_wr = 1'b1; bus_wdata = d;
    step();
    if (txq.size() < 8) txq.push_back(d); else m_tx_ovf = 1'b1;
    bus_wr = 1'b0;
  endtask

  task automatic rx_push(logic [31:0] d);
    eng_push = 1'b1; eng_rx_data = d;
    step();
    if (rxq.size() < 8) rxq.push_back(d); else m_rx_ovf = 1'b1;
    eng_push = 1'b0;
  endtask

  // monitor: compare head against scoreboard as it is consumed
  task automatic tx_pop(string req);
    eng_pop = 1'b1;
    check({req, " eng_tx_data"}, eng_tx_data, (txq.size() > 0) ? txq[0] : 32'h0);
    step();
    if (txq.size() > 0) void'(txq.pop_front()); else m_tx_udf = 1'b1;
    eng_pop = 1'b0;
  endtask

  task automatic rx_read(string req);
    bus_rd = 1'b1;
    check({req, " bus_rdata"}, bus_rdata, (rxq.size() > 0) ? rxq[0] : 32'h0);
    step();
    if (rxq.size() > 0) void'(rxq.pop_front()); else m_rx_udf = 1'b1;
    bus_rd = 1'b0;
  endtask

  task automatic clear_flags(logic [5:0] m);
    flag_clr_we = 1'b1; flag_clr_mask = m;
    step();
    if (m[1]) m_tx_ovf = 1'b0;
    if (m[2]) m_tx_udf = 1'b0;
    if (m[4]) m_rx_ovf = 1'b0;
    if (m[5]) m_rx_udf = 1'b0;
    flag_clr_we = 1'b0;
  endtask

  task automatic set_en(logic [5:0] e);
    irq_en_we = 1'b1; irq_en_wdata = e;
    step();
    en_m = e;
    irq_en_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; eng_pop = 0; eng_push = 0;
    tx_flush = 0; rx_flush = 0; flag_clr_we = 0; irq_en_we = 0;
    bus_wdata = '0; eng_rx_data = '0; flag_clr_mask = '0; irq_en_wdata = '0;
    tx_lvl_sel = 4'd2; rx_lvl_sel = 4'd3;
    m_tx_ovf = 0; m_tx_udf = 0; m_rx_ovf = 0; m_rx_udf = 0;
    en_m = '0; irq_exp = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_state("R11 reset");

    // R1/R4: ordering and transmit threshold crossing level 2
    tx_write(32'hA000_0001); check_state("R4");
    tx_write(32'hA000_0002); check_state("R4");
    tx_write(32'hA000_0003); check_state("R4");
    for (int i = 0; i < 3; i++) begin tx_pop("R1"); check_state("R1"); end

    // R6: overfill transmit queue, dropped word never appears
    for (int i = 0; i < 9; i++) tx_write(32'h0000_0100 + 32'(i));
    check_state("R6 tx full");
    for (int i = 0; i < 8; i++) tx_pop("R6 contents");
    // R7: pop on empty
    tx_pop("R7 tx empty"); check_state("R7");
    // R8: clear sticky flags (bits 0 and 3 ineffective)
    clear_flags(6'b111111); check_state("R8");

    // R2/R5: receive ordering and threshold at level 3
    for (int i = 0; i < 4; i++) begin rx_push(32'hB000_0000 + 32'(i)); check_state("R5"); end
    for (int i = 0; i < 4; i++) rx_read("R2");
    rx_read("R7 rx empty"); check_state("R7 rx");
    for (int i = 0; i < 9; i++) rx_push(32'hC000_0000 + 32'(i));
    check_state("R6 rx full");

    // R3: saturated selects
    rx_lvl_sel = 4'b1011; #1 check_state("R3 rx sat full");
    rx_read("R3"); check_state("R3 rx sat 7");
    rx_lvl_sel = 4'd7; #1 check_state("R3 rx 7");
    tx_lvl_sel = 4'b1100; #1 check_state("R3 tx sat empty");
    for (int i = 0; i < 8; i++) tx_write(32'hD000_0000 + 32'(i));
    check_state("R3 tx sat full");
    tx_lvl_sel = 4'd7; #1 check_state("R3 tx 7");

    // R9: flush full transmit queue with overflow set and a write in the same cycle
    tx_write(32'hDEAD_0000); check_state("R9 pre");
    tx_flush = 1'b1; bus_wr = 1'b1; bus_wdata = 32'hFEED_0000;
    step();
    txq.delete(); m_tx_ovf = 1'b0; m_tx_udf = 1'b0;
    tx_flush = 1'b0; bus_wr = 1'b0;
    check_state("R9 tx flush");
    check("R9 tx head", eng_tx_data, 32'h0);
    rx_flush = 1'b1; step();
    rxq.delete(); m_rx_ovf = 1'b0; m_rx_udf = 1'b0;
    rx_flush = 1'b0; check_state("R9 rx flush");

    // R10: interrupt gating and one-cycle registration
    rx_lvl_sel = 4'b1011; #1;
    set_en(6'b000100); check_state("R10 enabled");
    tx_pop("R10"); check_state("R10 same");
    step(); check_state("R10 raised");
    clear_flags(6'b000100); check_state("R10 clr");
    step(); check_state("R10 dropped");
    set_en(6'b000001); check_state("R10 trig en");
    step(); check_state("R10 trig irq");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule